// File: doc/BRIEF.md
# Priority Chip-Select Bank Decoder

This block decides which of a small set of programmable memory banks serves each external bus request. Every bank has two registers. The base register holds a base address, an address-type value, a port-size code, a write-protect flag, a burst-inhibit flag and a valid flag. The option register holds an address mask and an address-type mask. A request matches a bank when its address agrees with the bank's base in every bit the address mask enables, and its 3-bit address type agrees with the bank's type in every bit the type mask enables. When several banks match, the lowest-numbered one wins.

For the winning bank the block raises one chip-select line and presents that bank's port-size code and whether a burst may run. It also raises an internal acknowledge-enable. A write that hits a write-protected bank is turned into "no match": no chip select and no acknowledge-enable, so external logic has to end the cycle. The bank's sticky error bit is set, and software clears it by writing a one to it. Requests from an external master are matched with the address type forced to binary 100.

Registers are loaded through a plain write port. The request is captured in a register, matched combinationally, and the result is registered.

Top module: `cs_bank_decoder`

## Requirements
- R1: After reset every bank register and every error bit is zero, all banks are invalid, and a request gives all-zero outputs.
- R2: A request address matches a bank only when it equals the base address in every bit enabled in the address mask. Only address bits at or above GRAN take part in the match.
- R3: The request type matches only when it equals the bank's type field in every bit set in the type mask. A type mask of zero disables type checking for that bank.
- R4: At most one chip-select bit is high, and when several valid banks match, the bit of the lowest-numbered bank is raised.
- R5: `port_size` shows the winning bank's 2-bit port-size code. It is zero when there is no chip select.
- R6: A write whose winning bank has its write-protect flag set gives no chip select and a low `ack_en`. It does not fall through to a higher bank. Reads of that bank proceed normally.
- R7: A write-protect violation sets the winning bank's bit in `wp_err`, and the bit stays set. Writing to the status index clears each bit whose `reg_wdata` bit is 1. If a set and a clear arrive in the same cycle, the set wins.
- R8: When `req_ext` is high, the request is matched with address type 3'b100, whatever `req_type` holds.
- R9: `burst_ok` is high only when there is a chip select, the winning bank's burst-inhibit flag is clear, and the request is a read.
- R10: For a request strobed at rising edge N, the outputs show the result after edge N+1 and are all zero again one cycle later, unless another request follows.
- R11: When no valid bank matches, `cs`, `ack_en`, `port_size` and `burst_ok` are all zero.
- R12: The register map is as follows.
  - Index 2b writes the base register of bank b. Its fields are: base = data[ADDR_W-1:GRAN], type = [7:5], port size = [4:3], write-protect = [2], burst-inhibit = [1], valid = [0].
  - Index 2b+1 writes the option register of bank b. Its fields are: address mask = [ADDR_W-1:GRAN], type mask = [2:0].
  - Index 2*NBANK clears error bits.
  - Writes to other indices change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IW | Register index |
| reg_wdata | input | ADDR_W | Register write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Request address |
| req_type | input | 3 | Request address type |
| req_write | input | 1 | Request is a write |
| req_ext | input | 1 | Request comes from an external master |
| cs | output | NBANK | One-hot chip select |
| ack_en | output | 1 | Internal acknowledge-enable |
| port_size | output | 2 | Winning bank's port-size code |
| burst_ok | output | 1 | Burst allowed |
| wp_err | output | NBANK | Sticky write-protect error bits |

## Verification
The in-design assertions check, on every cycle, the following:
- the chip select is one-hot or zero;
- bursts never follow a write;
- a new error bit never comes with a chip select;
- error bits fall only after a clear write;
- a chip select never appears without a request two edges earlier.

Other behaviours can only be shown by the bench's scenarios, because they depend on what was programmed. These are:
- lowest-bank priority among overlapping windows;
- masked address and type comparison, including the zero type mask;
- the forced type for external masters;
- no fall-through past a protected bank;
- set-beats-clear on the error bits;
- writes to unused indices being ignored.

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder #(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 32,
  parameter int GRAN   = 8,
  localparam int IW = $clog2(2*NBANK+1),
  localparam int WW = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int HW = ADDR_W - GRAN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [IW-1:0]     reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_type,
  input  logic              req_write,
  input  logic              req_ext,
  output logic [NBANK-1:0]  cs,
  output logic              ack_en,
  output logic [1:0]        port_size,
  output logic              burst_ok,
  output logic [NBANK-1:0]  wp_err
);

  localparam logic [IW-1:0] STAT_IDX = IW'(2*NBANK);

  logic [HW-1:0] bk_base  [NBANK];
  logic [HW-1:0] bk_amask [NBANK];
  logic [2:0]    bk_type  [NBANK];
  logic [2:0]    bk_tmask [NBANK];
  logic [1:0]    bk_ps    [NBANK];
  logic [NBANK-1:0] bk_wp, bk_bi, bk_val, hit;

  logic          q_v, q_wr;
  logic [HW-1:0] q_addr;
  logic [2:0]    q_type;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bk_base[g]  <= '0;
        bk_type[g]  <= '0;
        bk_ps[g]    <= '0;
        bk_wp[g]    <= 1'b0;
        bk_bi[g]    <= 1'b0;
        bk_val[g]   <= 1'b0;
        bk_amask[g] <= '0;
        bk_tmask[g] <= '0;
      end else if (reg_we && reg_addr == IW'(2*g)) begin
        bk_base[g] <= reg_wdata[ADDR_W-1:GRAN];
        bk_type[g] <= reg_wdata[7:5];
        bk_ps[g]   <= reg_wdata[4:3];
        bk_wp[g]   <= reg_wdata[2];
        bk_bi[g]   <= reg_wdata[1];
        bk_val[g]  <= reg_wdata[0];
      end else if (reg_we && reg_addr == IW'(2*g+1)) begin
        bk_amask[g] <= reg_wdata[ADDR_W-1:GRAN];
        bk_tmask[g] <= reg_wdata[2:0];
      end
    end

    assign hit[g] = bk_val[g]
                  & ~|((q_addr ^ bk_base[g]) & bk_amask[g])
                  & ~|((q_type ^ bk_type[g]) & bk_tmask[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v    <= 1'b0;
      q_wr   <= 1'b0;
      q_addr <= '0;
      q_type <= '0;
    end else begin
      q_v <= req_valid;
      if (req_valid) begin
        q_wr   <= req_write;
        q_addr <= req_addr[ADDR_W-1:GRAN];
        q_type <= req_ext ? 3'b100 : req_type;
      end
    end
  end

  logic [WW-1:0] win;
  always_comb begin
    win = '0;
    for (int i = NBANK-1; i >= 0; i--)
      if (hit[i]) win = WW'(i);
  end

  logic             any_hit, blocked, grant;
  logic [NBANK-1:0] win_1h, err_set, err_clr;

  assign any_hit = |hit;
  assign win_1h  = {{(NBANK-1){1'b0}}, 1'b1} << win;
  assign blocked = q_v & any_hit & q_wr & bk_wp[win];
  assign grant   = q_v & any_hit & ~blocked;
  assign err_set = blocked ? win_1h : '0;
  assign err_clr = (reg_we && reg_addr == STAT_IDX) ? reg_wdata[NBANK-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs        <= '0;
      ack_en    <= 1'b0;
      port_size <= '0;
      burst_ok  <= 1'b0;
      wp_err    <= '0;
    end else begin
      cs        <= grant ? win_1h : '0;
      ack_en    <= grant;
      port_size <= grant ? bk_ps[win] : 2'b00;
      burst_ok  <= grant & ~bk_bi[win] & ~q_wr;
      wp_err    <= (wp_err & ~err_clr) | err_set;
    end
  end

  // R4
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));

  // R9
  burst_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_ok |-> ($past(!q_wr) && ack_en));

  // R6
  wp_nocs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wp_err & ~$past(wp_err))) |-> (cs == '0 && !ack_en));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(wp_err) & ~wp_err)) |-> $past(reg_we && reg_addr == STAT_IDX));

  // R10
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cs) |-> $past(req_valid, 2));

endmodule

// File: tb/cs_bank_decoder_tb.sv
module cs_bank_decoder_tb;
  localparam int NB = 4;
  localparam int AW = 32;
  localparam int GR = 8;
  localparam int IW = $clog2(2*NB+1);

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, req_valid = 0, req_write = 0, req_ext = 0;
  logic [IW-1:0] reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0, req_addr = '0;
  logic [2:0] req_type = '0;
  logic [NB-1:0] cs, wp_err;
  logic ack_en, burst_ok;
  logic [1:0] port_size;

  always #5 clk = ~clk;

  cs_bank_decoder #(.NBANK(NB), .ADDR_W(AW), .GRAN(GR)) u_dut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .req_valid, .req_addr,
    .req_type, .req_write, .req_ext, .cs, .ack_en, .port_size, .burst_ok, .wp_err);

  // reference model
  logic [AW-1:0] m_base [NB];
  logic [AW-1:0] m_opt  [NB];
  bit p_v, p_w; logic [AW-1:0] p_a; logic [2:0] p_t;
  logic [NB-1:0] e_cs, e_err; bit e_ack, e_bo; logic [1:0] e_ps;
  int vectors = 0, miscompares = 0, cyc = 0;
  string phase = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_base[i]) begin m_base[i] = 0; m_opt[i] = 0; end
      p_v = 0; p_w = 0; p_a = 0; p_t = 0;
      e_cs = 0; e_err = 0; e_ack = 0; e_bo = 0; e_ps = 0;
    end else begin
      int w; bit found;
      logic [NB-1:0] clr;
      w = -1; found = 0;
      e_cs = 0; e_ack = 0; e_bo = 0; e_ps = 0;
      if (p_v)
        for (int b = 0; b < NB; b++) begin
          if (!found && m_base[b][0] &&
              (((p_a ^ m_base[b]) & m_opt[b]) >> GR) == 0 &&
              ((p_t ^ m_base[b][7:5]) & m_opt[b][2:0]) == 0) begin
            found = 1; w = b;
          end
        end
      clr = (reg_we && reg_addr == IW'(2*NB)) ? reg_wdata[NB-1:0] : '0;
      e_err = e_err & ~clr;
      if (found) begin
        if (p_w && m_base[w][2]) e_err[w] = 1'b1;
        else begin
          e_cs[w] = 1'b1; e_ack = 1; e_ps = m_base[w][4:3];
          e_bo = !m_base[w][1] && !p_w;
        end
      end
      if (reg_we && reg_addr < IW'(2*NB)) begin
        if (reg_addr[0]) m_opt[reg_addr >> 1] = reg_wdata;
        else m_base[reg_addr >> 1] = reg_wdata;
      end
      p_v = req_valid;
      if (req_valid) begin
        p_w = req_write; p_a = req_addr; p_t = req_ext ? 3'b100 : req_type;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R4 cs", cs, e_cs);
    chk("R6 ack_en", ack_en, e_ack);
    chk("R5 port_size", port_size, e_ps);
    chk("R9 burst_ok", burst_ok, e_bo);
    chk("R7 wp_err", wp_err, e_err);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wr(int idx, logic [AW-1:0] d);
    @(negedge clk); reg_we = 1; reg_addr = IW'(idx); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rq(logic [AW-1:0] a, logic [2:0] t, bit w, bit x);
    @(negedge clk); req_valid = 1; req_addr = a; req_type = t; req_write = w; req_ext = x;
    @(negedge clk); req_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  // base word: {addr[31:8], type[7:5], ps[4:3], wp[2], bi[1], val[0]}
  function automatic logic [AW-1:0] bw(logic [23:0] a, logic [2:0] t, logic [1:0] ps,
                                       bit wp, bit bi, bit v);
    return {a, t, ps, wp, bi, v};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: nothing programmed, nothing matches
    phase = "R1"; rq(32'h1000_0000, 3'b000, 0, 0);
    // R12 / R2: bank0 wide window, bank1 narrow window
    phase = "R2";
    wr(0, bw(24'h100000, 3'b000, 2'd2, 0, 1, 1)); wr(1, 32'hF000_0000);
    wr(2, bw(24'h100000, 3'b000, 2'd1, 0, 0, 1)); wr(3, 32'hFF00_0000);
    rq(32'h1200_0000, 3'b010, 0, 0);
    rq(32'h2000_0000, 3'b010, 0, 0);  // R11 no match
    // R4: overlap -> bank0
    phase = "R4"; rq(32'h1000_0040, 3'b000, 0, 0);
    // R3 / R9: typed bank2, protected, burstable
    phase = "R3";
    wr(4, bw(24'h200000, 3'b101, 2'd3, 1, 0, 1)); wr(5, 32'hFFF0_0007);
    rq(32'h2000_0100, 3'b101, 0, 0);
    rq(32'h2000_0100, 3'b100, 0, 0);
    phase = "R9"; rq(32'h1000_0000, 3'b000, 1, 0);
    // R8: bank3 needs type 1xx; external forces 100
    phase = "R8";
    wr(6, bw(24'h300000, 3'b100, 2'd1, 0, 0, 1)); wr(7, 32'hF000_0004);
    rq(32'h3000_0000, 3'b011, 0, 0);
    rq(32'h3000_0000, 3'b011, 0, 1);
    rq(32'h2000_0000, 3'b101, 0, 1);
    // R6 / R7: protected write, no fall-through; clear; set beats clear
    phase = "R6"; rq(32'h2000_0000, 3'b101, 1, 0);
    phase = "R7"; wr(8, 32'h0000_0004);
    rq(32'h2000_0000, 3'b101, 1, 0);
    wr(8, 32'h0000_0003);
    @(negedge clk); req_valid = 1; req_addr = 32'h2000_0000; req_type = 3'b101; req_write = 1;
    @(negedge clk); req_valid = 0; reg_we = 1; reg_addr = IW'(8); reg_wdata = 32'h4;
    @(negedge clk); reg_we = 0;
    repeat (2) @(negedge clk);
    // R12: unused indices ignored; invalidating bank0 hands window to bank1
    phase = "R12";
    wr(9, 32'hFFFF_FFFF); wr(15, 32'hFFFF_FFFF);
    rq(32'h1000_0000, 3'b000, 0, 0);
    wr(0, 32'h1000_0000);
    rq(32'h1000_0000, 3'b000, 0, 0);
    // R10: back-to-back requests
    phase = "R10";
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); req_valid = 1; req_addr = {k[1:0] == 0 ? 4'h1 : 4'h3, 28'h0};
      req_type = 3'b100; req_write = k[0]; req_ext = 0;
    end
    @(negedge clk); req_valid = 0;
    // mixed random traffic, all requirements
    phase = "R5";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      req_valid = $urandom_range(0, 1);
      req_addr = {$urandom_range(0, 3) == 0 ? 4'h5 : 4'($urandom_range(1, 3)),
                  8'($urandom_range(0, 1)), 20'($urandom)};
      req_type = 3'($urandom); req_write = $urandom_range(0, 1); req_ext = $urandom_range(0, 1);
      reg_we = ($urandom_range(0, 15) == 0); reg_addr = IW'(8); reg_wdata = 32'($urandom);
    end
    @(negedge clk); req_valid = 0; reg_we = 0;
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule